// File: doc/BRIEF.md
# LED Blink and One-Shot Controller

This block drives a single indicator LED from one 8-bit control byte. The byte chooses how long one pattern cycle lasts, in units of 100 ms. It also chooses the shape of the light within that cycle: steady, a short flash, an even on/off square wave, or a single timed pulse that switches itself off. The last bit turns the whole output on or off. A prescaler divides the system clock down to a base tick, nominally 10 ms. A phase counter then counts ticks across the cycle, and a comparator turns the count into the LED level.

Software writes the byte with a one-cycle strobe. The strobe is a plain control input: the register has no back-pressure and accepts a write on any cycle. Every write restarts the timing from the start of the on phase. The readback output always shows the stored byte. When a single timed pulse has run its full length, the readback shows the enable bit cleared. The base tick length is a parameter, so a bench can use a tick of a few clocks in place of 10 ms.

Top module: `led_blink_ctrl`

## Requirements
- R1: After reset the stored control byte is 0x00 and `led_out` is low.
- R2: Bits 7..4 give the cycle length in units, where one unit is TICKS_PER_UNIT ticks and one tick is TICK_DIV clocks. The value 0 means 16 units.
- R3: With bits 3..1 = 0 and bit 0 = 1, `led_out` stays high for as long as the byte is unchanged.
- R4: With bits 3..1 = 2 and bit 0 = 1, `led_out` is high for the first half of every cycle and low for the second half. A length of 5 gives 250 ms on and 250 ms off.
- R5: With bits 3..1 = 1 and bit 0 = 1, `led_out` is high for the first tenth of every cycle and low for the rest. A length of 2 gives 20 ms on in every 200 ms.
- R6: With bit 0 = 0, `led_out` is low whatever the other bits hold, and `ctrl_rd` returns the byte as written.
- R7: With bits 3..1 = 3 and bit 0 = 1, `led_out` is high for exactly one cycle length. It then goes low, and from the same clock `ctrl_rd` shows bit 0 cleared while the other bits are unchanged.
- R8: A write during a running single pulse cancels it. If the new byte again asks for a single pulse with bit 0 = 1, a full new pulse starts from the write. Otherwise the new byte takes effect at once.
- R9: Bits 3..1 values 4 to 7 behave as steady on (the same as value 0).
- R10: Every write restarts both the prescaler and the phase counter, so the new pattern begins with its on phase on the clock after the write. Until a single pulse expires, `ctrl_rd` equals the byte last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle write strobe for the control byte |
| wr_data | input | 8 | Control byte to store when `wr_en` is high |
| led_out | output | 1 | LED drive, high means lit |
| ctrl_rd | output | 8 | Readback of the stored control byte |

## Verification
The bench tries every pattern code with bit 0 set: steady, tenth, half, single pulse, and two of the spare codes. It uses several cycle lengths, including the zero code, so that a wrong scaling of the length field, a wrong on fraction or a missed wrap each show as an edge in the wrong clock. It writes the same byte with bit 0 clear to separate the enable gating from the pattern logic. Rewrites in the middle of an off phase and in the middle of a single pulse show whether the counters restart, whether a pulse can be retriggered or cancelled, and whether the readback loses its enable bit only at expiry.

// File: rtl/led_blink_pkg.sv
package led_blink_pkg;

  // Shape of the light within one cycle (bits 3..1 of the control byte)
  typedef enum logic [2:0] {
    SHAPE_STEADY  = 3'd0,
    SHAPE_TENTH   = 3'd1,
    SHAPE_HALF    = 3'd2,
    SHAPE_ONESHOT = 3'd3
  } shape_e;

  // Control byte layout
  typedef struct packed {
    logic [3:0] len_units;  // cycle length in units, 0 stands for 16
    logic [2:0] shape;      // shape code, 4..7 handled as steady
    logic       enable;     // master enable
  } ctrl_t;

  // Length field to unit count (1..16)
  function automatic logic [4:0] len_to_units(input logic [3:0] len);
    return (len == 4'd0) ? 5'd16 : {1'b0, len};
  endfunction

endpackage

// File: rtl/led_tick_gen.sv
module led_tick_gen #(
  parameter int TICK_DIV = 500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);

  generate
    if (TICK_DIV <= 1) begin : g_every_clock
      assign tick = 1'b1;
    end else begin : g_divider
      localparam int CNT_W = $clog2(TICK_DIV);
      localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);

      logic [CNT_W-1:0] div_cnt;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          div_cnt <= '0;
        end else if (restart) begin
          div_cnt <= '0;
        end else if (div_cnt == LAST) begin
          div_cnt <= '0;
        end else begin
          div_cnt <= div_cnt + 1'b1;
        end
      end

      assign tick = (div_cnt == LAST);

      // ticks are isolated single-cycle pulses
      p_tick_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
      // a restart always leaves the divider at its first count
      p_div_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (div_cnt == '0));
    end
  endgenerate

endmodule

// File: rtl/led_phase_timer.sv
module led_phase_timer #(
  parameter int PH_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic            tick,
  input  logic [PH_W-1:0] cycle_last,
  output logic [PH_W-1:0] phase,
  output logic            wrap
);

  assign wrap = tick && (phase == cycle_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (restart) begin
      phase <= '0;
    end else if (wrap) begin
      phase <= '0;
    end else if (tick) begin
      phase <= phase + 1'b1;
    end
  end

  // phase never runs past the end of the cycle
  p_phase_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= cycle_last);
  // a write restarts the cycle at its first tick
  p_phase_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (phase == '0));
  // without a tick or restart the phase holds
  p_phase_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> $stable(phase));

endmodule

// File: rtl/led_ctrl_reg.sv
module led_ctrl_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       expire,
  output logic [7:0] ctrl_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= 8'h00;
    end else if (wr_en) begin
      ctrl_q <= wr_data;            // a write wins over an expiry
    end else if (expire) begin
      ctrl_q <= {ctrl_q[7:1], 1'b0};
    end
  end

  // a written byte is stored whole
  p_write_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ctrl_q == $past(wr_data)));
  // expiry clears only the enable bit
  p_oneshot_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !wr_en) |=> (!ctrl_q[0] && ctrl_q[7:1] == $past(ctrl_q[7:1])));
  // without a write or expiry the byte holds
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !expire) |=> $stable(ctrl_q));

endmodule

// File: rtl/led_shape.sv
module led_shape
  import led_blink_pkg::*;
#(
  parameter int TICKS_PER_UNIT = 10,
  parameter int PH_W           = 8
) (
  input  ctrl_t           ctrl,
  input  logic [PH_W-1:0] phase,
  output logic [PH_W-1:0] cycle_last,
  output logic            oneshot_armed,
  output logic            led
);

  localparam logic [PH_W-1:0] TPU_W   = PH_W'(TICKS_PER_UNIT);
  localparam logic [PH_W-1:0] HALF_W  = PH_W'(TICKS_PER_UNIT / 2);
  localparam logic [PH_W-1:0] TENTH_W = PH_W'(TICKS_PER_UNIT / 10);

  logic [PH_W-1:0] units_w;
  logic [PH_W-1:0] cycle_ticks;
  logic [PH_W-1:0] half_ticks;
  logic [PH_W-1:0] tenth_ticks;

  always_comb begin
    units_w     = PH_W'(len_to_units(ctrl.len_units));
    cycle_ticks = units_w * TPU_W;
    half_ticks  = units_w * HALF_W;
    tenth_ticks = units_w * TENTH_W;
    cycle_last  = cycle_ticks - 1'b1;
  end

  always_comb begin
    oneshot_armed = 1'b0;
    led           = 1'b0;
    if (ctrl.enable) begin
      unique case (ctrl.shape)
        SHAPE_TENTH:   led = (phase < tenth_ticks);
        SHAPE_HALF:    led = (phase < half_ticks);
        SHAPE_ONESHOT: begin
          led           = 1'b1;
          oneshot_armed = 1'b1;
        end
        default:       led = 1'b1;   // steady and spare codes
      endcase
    end
  end

endmodule

// File: rtl/led_blink_ctrl.sv
module led_blink_ctrl
  import led_blink_pkg::*;
#(
  parameter int TICK_DIV       = 500_000,
  parameter int TICKS_PER_UNIT = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic       led_out,
  output logic [7:0] ctrl_rd
);

  localparam int MAX_TICKS = 16 * TICKS_PER_UNIT;
  localparam int PH_W      = $clog2(MAX_TICKS + 1);

  logic            tick;
  logic            wrap;
  logic            expire;
  logic            oneshot_armed;
  logic [PH_W-1:0] phase;
  logic [PH_W-1:0] cycle_last;
  logic [7:0]      ctrl_q;
  ctrl_t           ctrl;

  assign ctrl    = ctrl_t'(ctrl_q);
  assign ctrl_rd = ctrl_q;

  led_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (wr_en),
    .tick    (tick)
  );

  led_phase_timer #(.PH_W(PH_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (wr_en),
    .tick       (tick),
    .cycle_last (cycle_last),
    .phase      (phase),
    .wrap       (wrap)
  );

  led_shape #(.TICKS_PER_UNIT(TICKS_PER_UNIT), .PH_W(PH_W)) u_shape (
    .ctrl          (ctrl),
    .phase         (phase),
    .cycle_last    (cycle_last),
    .oneshot_armed (oneshot_armed),
    .led           (led_out)
  );

  assign expire = wrap && oneshot_armed;

  led_ctrl_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .expire  (expire),
    .ctrl_q  (ctrl_q)
  );

  // disabled output stays dark
  p_disabled_dark_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_rd[0] |-> !led_out);
  // steady code with enable keeps the LED lit
  p_steady_lit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rd[0] && ctrl_rd[3:1] == 3'd0) |-> led_out);
  // spare codes light like steady
  p_spare_lit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rd[0] && ctrl_rd[3]) |-> led_out);
  // after an unwritten expiry the LED is dark
  p_expire_dark_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !wr_en) |=> !led_out);
  // reset leaves everything cleared
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (ctrl_rd == 8'h00 && !led_out));

endmodule

// File: tb/led_blink_ctrl_tb_top.sv
module led_blink_ctrl_tb_top;

  localparam int DIV = 4;
  localparam int TPU = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       led_out;
  logic [7:0] ctrl_rd;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  logic [8:0] q_val[$];
  string      q_tag[$];

  always #4 clk = ~clk;  // 125 MHz

  led_blink_ctrl #(.TICK_DIV(DIV), .TICKS_PER_UNIT(TPU)) dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .led_out (led_out),
    .ctrl_rd (ctrl_rd)
  );

  // expected {led, readback} c clocks after the write of d
  function automatic logic [8:0] model(input logic [7:0] d, input int c);
    int units, cycle, ticks, ph;
    logic led;
    logic [7:0] rd;
    units = (d[7:4] == 4'd0) ? 16 : int'(d[7:4]);
    cycle = units * TPU;
    ticks = c / DIV;
    ph    = ticks % cycle;
    rd    = d;
    led   = 1'b0;
    if (d[0]) begin
      case (d[3:1])
        3'd1: led = (ph < units * TPU / 10);
        3'd2: led = (ph < units * TPU / 2);
        3'd3: begin
          led = (ticks < cycle);
          if (ticks >= cycle) rd = {d[7:1], 1'b0};
        end
        default: led = 1'b1;
      endcase
    end
    return {led, rd};
  endfunction

  // driver: write a byte and queue n expected samples
  task automatic do_write(input logic [7:0] d, input int n, input string tag);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d;
    for (int c = 0; c < n; c++) begin
      q_val.push_back(model(d, c));
      q_tag.push_back(tag);
    end
    @(negedge clk);
    wr_en = 1'b0;
    wait (q_val.size() == 0);
  endtask

  // driver: queue n samples of a fixed state with no write
  task automatic observe(input logic [8:0] v, input int n, input string tag);
    @(negedge clk);
    for (int c = 0; c < n; c++) begin
      q_val.push_back(v);
      q_tag.push_back(tag);
    end
    wait (q_val.size() == 0);
  endtask

  // monitor: compare two time units after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q_val.size() > 0) begin
        logic [8:0] v;
        string t;
        v = q_val.pop_front();
        t = q_tag.pop_front();
        total++;
        if ({led_out, ctrl_rd} !== v) begin
          bad++;
          $display("FAIL %s: led=%0b rd=%02h expected led=%0b rd=%02h",
                   t, led_out, ctrl_rd, v[8], v[7:0]);
        end
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      bad++;
      total++;
      $display("FAIL watchdog: cycles=%0d expected completion", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    observe(9'h000, 20, "R1 reset state");
    do_write(8'h31, 300, "R3 steady len3");
    do_write(8'h55, 450, "R4 half len5");
    do_write(8'h23, 250, "R5 tenth len2");
    do_write(8'h05, 1400, "R2 zero length means 16 units");
    do_write(8'h54, 300, "R6 disabled half");
    do_write(8'h17, 120, "R7 one-shot len1 expiry");
    do_write(8'h07, 700, "R2 R7 one-shot zero length");
    do_write(8'h27, 50, "R8 one-shot first");
    do_write(8'h27, 150, "R8 one-shot retrigger");
    do_write(8'h27, 30, "R8 one-shot before cancel");
    do_write(8'h26, 100, "R8 one-shot cancelled");
    do_write(8'h4D, 300, "R9 spare code 6");
    do_write(8'h3B, 200, "R9 spare code 5");
    do_write(8'h55, 130, "R10 half into off phase");
    do_write(8'h55, 200, "R10 rewrite restarts on phase");
    do_write(8'h23, 30, "R10 switch to tenth mid cycle");
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule